// File: doc/BRIEF.md
# Immediate Extension Prefix Unit

This unit sits beside an instruction decoder. It collects up to two prefix instructions that carry 13-bit extension payloads. When the next ordinary instruction takes its short immediate, the unit joins the held payloads to that immediate and forms one wide operand. The decoder signals each prefix with a strobe. It signals the instruction that uses the immediate with a consume strobe, which carries the immediate field, its width in bits and its kind.

The number of held prefixes sets the size of the result: none gives the plain field, one gives a 16-bit operand and two give a 24-bit operand. Signed kinds take their sign from the top bit of the extended operand. A plain field is never treated as signed. Address-step kinds work differently: with no prefix the field is the access size, with one prefix the step is the payload, and with two prefixes the step is a 24-bit value built from both payloads.

Held prefixes are thrown away when an interrupt is taken. They are also ignored by an instruction in a delayed-branch slot. The result, the number of prefixes actually used and a valid flag appear one clock after the consume.

Top module: `imm_ext_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, imm_valid is 0, ext_count is 0 and imm_out is 0.
- R2: With no prefix held, a consume returns the low use_width bits of use_field, zero-extended for every kind, with ext_count 0. Field bits at or above use_width are ignored, and widths above 13 count as 13. use_kind encodes 0 = unsigned, 1 = signed, 2 = address step, and 3 acts as unsigned.
- R3: With one prefix held and an unsigned kind, the result is bits 15..0 of {payload, field}, where the field is use_width bits wide. Bits 23..16 are 0 and ext_count is 1. For example, payload 0x1ff with a 7-bit field 0x7f gives 0x00ffff.
- R4: With two prefixes held and a non-step kind, the result is bits 23..0 of {older payload, newer payload, field}, with ext_count 2.
- R5: With a signed kind and one prefix, bit 15 of the result is copied into bits 23..16. With two prefixes the 24-bit value is used as it is.
- R6: With the step kind, the result is the masked field when no prefix is held, the newer payload zero-extended when one is held, and {older payload bits 10..0, newer payload} when two are held.
- R7: A third or later prefix in a row drops the oldest held payload. ext_count never goes above 2.
- R8: A consume with in_dslot = 1 ignores any held prefix and reports ext_count 0. The held prefixes are cleared all the same.
- R9: irq_taken clears the held prefixes. In the same cycle it cancels a consume, which produces no result, and it discards a prefix.
- R10: Every accepted consume clears the held prefixes, so the next consume starts with none held.
- R11: When a prefix strobe and a consume arrive in the same cycle, the consume is served with the earlier state and the prefix is discarded.
- R12: imm_valid is 1 for exactly one cycle after each accepted consume. imm_out and ext_count keep their values while imm_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_valid | input | 1 | A decoded prefix instruction is present |
| pfx_payload | input | 13 | Prefix extension payload |
| use_valid | input | 1 | An instruction consumes its short immediate |
| use_field | input | 13 | Short immediate field, right-aligned |
| use_width | input | 4 | Bit width of the short field |
| use_kind | input | 2 | 0 unsigned, 1 signed, 2 address step |
| irq_taken | input | 1 | An interrupt is taken this cycle |
| in_dslot | input | 1 | The consuming instruction sits in a delayed-branch slot |
| imm_out | output | 24 | Assembled operand |
| ext_count | output | 2 | Number of prefixes applied (0, 1 or 2) |
| imm_valid | output | 1 | imm_out and ext_count were updated by the last cycle's consume |

## Verification
Some properties are checked on every cycle. The extension count never reaches 3. A result appears only one cycle after a consume that was not cancelled, and an interrupt always suppresses the next result. A delay-slot consume always reports zero prefixes. One-prefix results are zero above bit 15 when unsigned and sign-copied when signed. Outputs hold while no result is valid.

Other behaviour depends on history and only the bench scenarios can show it. This covers how payloads are ordered and dropped after a third prefix, clearing after an interrupt or delay slot, the two-prefix concatenation and the step values. The bench compares every cycle against its queue-based model.

// File: rtl/imm_ext_unit.sv
module imm_ext_unit #(
  parameter int PAY_W = 13,
  parameter int MID_W = 16,
  parameter int OUT_W = 24,
  localparam int WID_W = $clog2(PAY_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfx_valid,
  input  logic [PAY_W-1:0] pfx_payload,
  input  logic             use_valid,
  input  logic [PAY_W-1:0] use_field,
  input  logic [WID_W-1:0] use_width,
  input  logic [1:0]       use_kind,
  input  logic             irq_taken,
  input  logic             in_dslot,
  output logic [OUT_W-1:0] imm_out,
  output logic [1:0]       ext_count,
  output logic             imm_valid
);
  localparam int CAT_W = 3 * PAY_W;
  localparam int HI_W  = OUT_W - PAY_W;
  localparam logic [1:0] KIND_SGN  = 2'd1;
  localparam logic [1:0] KIND_STEP = 2'd2;

  logic [1:0]       held_q;
  logic [PAY_W-1:0] older_q, newer_q;
  logic             take;
  logic [1:0]       k;
  logic [WID_W-1:0] w_eff;
  logic [PAY_W-1:0] fld;
  logic [CAT_W-1:0] cat1, cat2;
  logic [OUT_W-1:0] res;

  assign take  = use_valid & ~irq_taken;
  assign k     = in_dslot ? 2'd0 : held_q;
  assign w_eff = (use_width > WID_W'(PAY_W)) ? WID_W'(PAY_W) : use_width;
  assign fld   = use_field & ~({PAY_W{1'b1}} << w_eff);
  assign cat1  = (CAT_W'(newer_q) << w_eff) | CAT_W'(fld);
  assign cat2  = cat1 | (CAT_W'(older_q) << (PAY_W + int'(w_eff)));

  always_comb begin
    if (use_kind == KIND_STEP) begin
      case (k)
        2'd0:    res = OUT_W'(fld);
        2'd1:    res = OUT_W'(newer_q);
        default: res = {older_q[HI_W-1:0], newer_q};
      endcase
    end else begin
      case (k)
        2'd0:    res = OUT_W'(fld);
        2'd1:    res = (use_kind == KIND_SGN)
                       ? {{(OUT_W-MID_W){cat1[MID_W-1]}}, cat1[MID_W-1:0]}
                       : OUT_W'(cat1[MID_W-1:0]);
        default: res = cat2[OUT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 2'd0;
      older_q <= '0;
      newer_q <= '0;
    end else if (irq_taken || use_valid) begin
      held_q <= 2'd0;
    end else if (pfx_valid) begin
      older_q <= newer_q;
      newer_q <= pfx_payload;
      if (held_q != 2'd2) held_q <= held_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imm_valid <= 1'b0;
      imm_out   <= '0;
      ext_count <= 2'd0;
    end else begin
      imm_valid <= take;
      if (take) begin
        imm_out   <= res;
        ext_count <= k;
      end
    end
  end
endmodule

// File: rtl/imm_ext_unit_chk.sv
module imm_ext_unit_chk #(
  parameter int OUT_W = 24,
  parameter int MID_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             use_valid,
  input logic [1:0]       use_kind,
  input logic             irq_taken,
  input logic             in_dslot,
  input logic [OUT_W-1:0] imm_out,
  input logic [1:0]       ext_count,
  input logic             imm_valid
);
  p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_count != 2'd3);

  p_valid_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    imm_valid |-> $past(use_valid && !irq_taken));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !imm_valid |-> ($stable(imm_out) && $stable(ext_count)));

  p_irq_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_taken) |-> !imm_valid);

  p_dslot_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_valid && $past(in_dslot)) |-> ext_count == 2'd0);

  p_plain_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_valid && ext_count == 2'd0) |-> imm_out[OUT_W-1:13] == '0);

  p_unsigned_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_valid && ext_count == 2'd1 && $past(use_kind) != 2'd1)
      |-> imm_out[OUT_W-1:MID_W] == '0);

  p_signed_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_valid && ext_count == 2'd1 && $past(use_kind) == 2'd1)
      |-> imm_out[OUT_W-1:MID_W] == {(OUT_W-MID_W){imm_out[MID_W-1]}});
endmodule

bind imm_ext_unit imm_ext_unit_chk #(.OUT_W(OUT_W), .MID_W(MID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .use_valid(use_valid), .use_kind(use_kind),
  .irq_taken(irq_taken), .in_dslot(in_dslot), .imm_out(imm_out),
  .ext_count(ext_count), .imm_valid(imm_valid)
);

// File: tb/imm_ext_unit_tb.sv
module imm_ext_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfx_valid = 1'b0;
  logic [12:0] pfx_payload = '0;
  logic        use_valid = 1'b0;
  logic [12:0] use_field = '0;
  logic [3:0]  use_width = '0;
  logic [1:0]  use_kind = '0;
  logic        irq_taken = 1'b0;
  logic        in_dslot = 1'b0;
  logic [23:0] imm_out;
  logic [1:0]  ext_count;
  logic        imm_valid;

  int    n_tests = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  imm_ext_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_payload(pfx_payload),
    .use_valid(use_valid), .use_field(use_field), .use_width(use_width),
    .use_kind(use_kind), .irq_taken(irq_taken), .in_dslot(in_dslot),
    .imm_out(imm_out), .ext_count(ext_count), .imm_valid(imm_valid)
  );

  int          pq[$];
  logic        e_valid = 0;
  logic [23:0] e_imm = 0;
  logic [1:0]  e_cnt = 0;

  function automatic logic [23:0] ref_val(int k, logic [1:0] kind, int w,
                                          longint fld, longint older, longint newer);
    longint m, v;
    if (w > 13) w = 13;
    m = fld & ((64'd1 << w) - 1);
    if (kind == 2'd2) begin
      if (k == 0) v = m;
      else if (k == 1) v = newer;
      else v = ((older & 64'h7ff) << 13) | newer;
    end else begin
      if (k == 0) v = m;
      else if (k == 1) begin
        v = ((newer << w) | m) & 64'hffff;
        if (kind == 2'd1 && v[15]) v = v | 64'hff0000;
      end else v = ((older << (13 + w)) | (newer << w) | m) & 64'hffffff;
    end
    return v[23:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pq.delete();
      e_valid = 0; e_imm = 0; e_cnt = 0;
    end else if (irq_taken) begin
      pq.delete();
      e_valid = 0;
    end else if (use_valid) begin
      int k;
      int ol, nw;
      k  = in_dslot ? 0 : pq.size();
      nw = (pq.size() >= 1) ? pq[pq.size()-1] : 0;
      ol = (pq.size() >= 2) ? pq[0] : 0;
      e_imm   = ref_val(k, use_kind, int'(use_width), longint'(use_field),
                        longint'(ol), longint'(nw));
      e_cnt   = 2'(k);
      e_valid = 1;
      pq.delete();
    end else begin
      e_valid = 0;
      if (pfx_valid) begin
        pq.push_back(int'(pfx_payload));
        if (pq.size() > 2) void'(pq.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (imm_valid !== e_valid || imm_out !== e_imm || ext_count !== e_cnt) begin
        n_fail++;
        $display("FAIL %s: valid/imm/count got %0b/%06h/%0d expected %0b/%06h/%0d",
                 cur_req, imm_valid, imm_out, ext_count, e_valid, e_imm, e_cnt);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    pfx_valid = 0; use_valid = 0; irq_taken = 0; in_dslot = 0;
  endtask

  task automatic pfx(logic [12:0] p);
    @(negedge clk);
    pfx_valid = 1; pfx_payload = p; use_valid = 0; irq_taken = 0; in_dslot = 0;
  endtask

  task automatic use_imm(logic [12:0] f, logic [3:0] w, logic [1:0] kd,
                         logic ds, logic irq, logic pv);
    @(negedge clk);
    pfx_valid = pv; pfx_payload = 13'h1555; use_valid = 1; use_field = f;
    use_width = w; use_kind = kd; in_dslot = ds; irq_taken = irq;
  endtask

  task automatic irq_only(logic pv);
    @(negedge clk);
    pfx_valid = pv; pfx_payload = 13'h0abc; use_valid = 0; irq_taken = 1; in_dslot = 0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(); idle();

    cur_req = "R2";
    use_imm(13'h07f, 4'd7, 2'd0, 0, 0, 0); idle();
    use_imm(13'h07f, 4'd7, 2'd1, 0, 0, 0); idle();
    use_imm(13'h1fff, 4'd5, 2'd1, 0, 0, 0); idle();
    use_imm(13'h1fff, 4'd15, 2'd3, 0, 0, 0); idle();

    cur_req = "R3";
    pfx(13'h1ff); use_imm(13'h07f, 4'd7, 2'd0, 0, 0, 0); idle();
    pfx(13'h1fff); use_imm(13'h1fff, 4'd13, 2'd0, 0, 0, 0); idle();

    cur_req = "R5";
    pfx(13'h1ff); use_imm(13'h07f, 4'd7, 2'd1, 0, 0, 0); idle();
    pfx(13'h0ff); use_imm(13'h07f, 4'd7, 2'd1, 0, 0, 0); idle();
    pfx(13'h1abc); pfx(13'h0123); use_imm(13'h055, 4'd7, 2'd1, 0, 0, 0); idle();

    cur_req = "R4";
    pfx(13'h1234); pfx(13'h0abc); use_imm(13'h03c, 4'd7, 2'd0, 0, 0, 0); idle();
    pfx(13'h1fff); idle(); pfx(13'h0001); use_imm(13'h7, 4'd3, 2'd0, 0, 0, 0); idle();

    cur_req = "R6";
    use_imm(13'h4, 4'd3, 2'd2, 0, 0, 0); idle();
    pfx(13'h1e01); use_imm(13'h2, 4'd3, 2'd2, 0, 0, 0); idle();
    pfx(13'h1f0f); pfx(13'h0777); use_imm(13'h1, 4'd3, 2'd2, 0, 0, 0); idle();

    cur_req = "R7";
    pfx(13'h0111); pfx(13'h0222); pfx(13'h0333); use_imm(13'h01, 4'd7, 2'd0, 0, 0, 0); idle();
    pfx(13'h1); pfx(13'h2); pfx(13'h3); pfx(13'h4); use_imm(13'h2, 4'd3, 2'd2, 0, 0, 0); idle();

    cur_req = "R8";
    pfx(13'h1ff); pfx(13'h1ff); use_imm(13'h07f, 4'd7, 2'd1, 1, 0, 0); idle();
    use_imm(13'h07f, 4'd7, 2'd0, 0, 0, 0); idle();

    cur_req = "R9";
    pfx(13'h0aaa); irq_only(0); use_imm(13'h11, 4'd7, 2'd0, 0, 0, 0); idle();
    pfx(13'h0aaa); use_imm(13'h22, 4'd7, 2'd0, 0, 1, 0); idle();
    use_imm(13'h23, 4'd7, 2'd0, 0, 0, 0); idle();
    irq_only(1); use_imm(13'h24, 4'd7, 2'd0, 0, 0, 0); idle();

    cur_req = "R10";
    pfx(13'h0f0f); use_imm(13'h01, 4'd7, 2'd0, 0, 0, 0);
    use_imm(13'h02, 4'd7, 2'd0, 0, 0, 0); idle();

    cur_req = "R11";
    use_imm(13'h33, 4'd7, 2'd0, 0, 0, 1);
    use_imm(13'h34, 4'd7, 2'd0, 0, 0, 0); idle();

    cur_req = "R12";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pfx_valid   = ($urandom_range(0, 2) == 0);
      pfx_payload = 13'($urandom);
      use_valid   = ($urandom_range(0, 3) == 0);
      use_field   = 13'($urandom);
      use_width   = 4'($urandom_range(0, 15));
      use_kind    = 2'($urandom);
      irq_taken   = ($urandom_range(0, 9) == 0);
      in_dslot    = ($urandom_range(0, 5) == 0);
    end
    idle(); idle(); idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL %s: watchdog expired, got running expected finished", cur_req);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule